// File: doc/BRIEF.md
# I2C Slave Byte Engine with Packet-Error Check

This block is the target side of an I2C bus. SCL and SDA are taken in as plain inputs and sampled on the system clock through a two-flop synchroniser. SDA is driven back as an open-drain enable. The engine sees START, STOP and repeated START, compares the 7-bit calling address against `own_addr`, and moves data bytes MSB first. The acknowledge goes in the ninth SCL period.

A CPU reaches four byte-wide registers through a simple select/read/write port: a transmit holding register, a receive holding register, a CRC register and a status register. The CRC-8 packet-error check runs over every bit on the bus from the START onward, including the address. After each data byte, the result is latched into the CRC register and a ready flag is raised. To send the check byte, software copies it into the transmit register.

Top module: `i2c_pec_slave`

## Requirements
- R1: After reset the status register reads 0x0A (`tx_empty` and `nack` set, all other flags clear), the transmit register reads 0x00 and `sda_oe` is low.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high, both judged on the synchronised lines. A calling address other than `own_addr` gets no acknowledge and raises no flag, and the block stays silent until the next START.
- R3: When the first seven bits after a START equal `own_addr`, the block pulls SDA low for the whole ninth SCL high period.
- R4: The direction flag (status bit 4) takes the eighth address bit (1 = master reads) only when a matching address byte completes. It holds its value at all other times.
- R5: In slave receive, each data byte moves into the receive register, sets `rx_full` (status bit 0) and is acknowledged. A CPU read of select 1 clears `rx_full`.
- R6: A CPU write to select 0 loads the transmit register and clears `tx_empty` (status bit 1). In slave transmit, the register's byte moves into the shifter on the SCL falling edge that ends an acknowledge, which sets `tx_empty`. The byte is sent MSB first.
- R7: If the transmit register is empty when a transmit byte must begin, the block sends 0xFF.
- R8: In slave transmit, the `nack` flag (status bit 3) takes the SDA level sampled at the ninth SCL rising edge. On a NACK the block keeps SDA released and sets the selected flag (status bit 5) to 0.
- R9: The CRC uses polynomial x^8+x^2+x+1 (0x07), starts at 0x00 on each START or repeated START, and covers the address byte and all data bytes MSB first. After each data byte the CRC register (select 2) holds the CRC up to and including that byte, and `crc_rdy` (status bit 2) is set. A CPU read of select 2 clears `crc_rdy`.
- R10: A repeated START during a transfer restarts address matching and the CRC, and the new R/W bit decides the direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Address this slave answers |
| reg_sel | input | 2 | 0 transmit data, 1 receive data, 2 CRC, 3 status |
| reg_wr | input | 1 | Write strobe, one clock |
| reg_rd | input | 1 | Read strobe, one clock; clears flags on select 1 and 2 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register, combinational |

## Verification
The properties assume a well-behaved master. It moves SDA only while SCL is low, except when it makes START or STOP. It keeps each SCL phase longer than the synchroniser delay. It never tries START or STOP while the slave holds SDA low. The bench master meets these conditions with quarter bit periods of ten system clocks. It changes SDA one quarter period after SCL falls. It ends every read with a NACK before it issues STOP or a repeated START.

// File: rtl/i2c_pec_slave.sv
module i2c_pec_slave #(
  parameter logic [7:0] CRC_POLY = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [6:0] own_addr,
  input  logic [1:0] reg_sel,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);

  localparam logic [2:0] ST_IDLE  = 3'd0;
  localparam logic [2:0] ST_ADDR  = 3'd1;
  localparam logic [2:0] ST_RX    = 3'd2;
  localparam logic [2:0] ST_TX    = 3'd3;
  localparam logic [2:0] ST_ACKW  = 3'd4;
  localparam logic [2:0] ST_ACK   = 3'd5;
  localparam logic [2:0] ST_TXACK = 3'd6;

  localparam logic [1:0] SEL_TXD = 2'd0;
  localparam logic [1:0] SEL_RXD = 2'd1;
  localparam logic [1:0] SEL_CRC = 2'd2;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic b);
    return {c[6:0], 1'b0} ^ ((c[7] ^ b) ? CRC_POLY : 8'h00);
  endfunction

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic       scl_s, sda_s;
  logic [2:0] state, bitcnt;
  logic [7:0] shreg, tx_reg, rx_reg, crc, crc_dr;
  logic       tx_empty, rx_full, crc_rdy, nack, dir;

  assign scl_s = scl_sy[1];
  assign sda_s = sda_sy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end

  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;

  wire [7:0] sh_in    = {shreg[6:0], sda_s};
  wire [7:0] crc_in   = crc_step(crc, sda_s);
  wire [7:0] crc_out  = crc_step(crc, shreg[7]);
  wire [7:0] tx_byte  = tx_empty ? 8'hFF : tx_reg;
  wire       addr_hit = sh_in[7:1] == own_addr;
  wire       selected = (state != ST_IDLE) && (state != ST_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitcnt   <= 3'd0;
      shreg    <= 8'h00;
      tx_reg   <= 8'h00;
      rx_reg   <= 8'h00;
      crc      <= 8'h00;
      crc_dr   <= 8'h00;
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
      crc_rdy  <= 1'b0;
      nack     <= 1'b1;
      dir      <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      if (reg_rd && reg_sel == SEL_RXD) rx_full <= 1'b0;
      if (reg_rd && reg_sel == SEL_CRC) crc_rdy <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= 3'd0;
        crc    <= 8'h00;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_RX:
            if (scl_rise) begin
              shreg  <= sh_in;
              crc    <= crc_in;
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) begin
                if (state == ST_ADDR) begin
                  if (addr_hit) begin
                    dir   <= sh_in[0];
                    state <= ST_ACKW;
                  end else begin
                    state <= ST_IDLE;
                  end
                end else begin
                  rx_reg  <= sh_in;
                  rx_full <= 1'b1;
                  crc_dr  <= crc_in;
                  crc_rdy <= 1'b1;
                  state   <= ST_ACKW;
                end
              end
            end
          ST_ACKW:
            if (scl_fall) begin
              sda_oe <= 1'b1;
              state  <= ST_ACK;
            end
          ST_ACK, ST_TXACK: begin
            if (scl_rise && state == ST_TXACK) nack <= sda_s;
            if (scl_fall) begin
              bitcnt <= 3'd0;
              if ((state == ST_ACK && dir) || (state == ST_TXACK && !nack)) begin
                shreg    <= tx_byte;
                sda_oe   <= ~tx_byte[7];
                tx_empty <= 1'b1;
                state    <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= (state == ST_ACK) ? ST_RX : ST_IDLE;
              end
            end
          end
          ST_TX:
            if (scl_fall) begin
              crc    <= crc_out;
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) begin
                sda_oe  <= 1'b0;
                crc_dr  <= crc_out;
                crc_rdy <= 1'b1;
                state   <= ST_TXACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b1};
                sda_oe <= ~shreg[6];
              end
            end
          default: state <= ST_IDLE;
        endcase
      end
      if (reg_wr && reg_sel == SEL_TXD) begin
        tx_reg   <= reg_wdata;
        tx_empty <= 1'b0;
      end
    end

  always_comb
    case (reg_sel)
      SEL_TXD: reg_rdata = tx_reg;
      SEL_RXD: reg_rdata = rx_reg;
      SEL_CRC: reg_rdata = crc_dr;
      default: reg_rdata = {2'b00, selected, dir, nack, crc_rdy, tx_empty, rx_full};
    endcase

endmodule

// File: rtl/i2c_pec_slave_chk.sv
module i2c_pec_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_q,
  input logic       sda_oe,
  input logic [2:0] state,
  input logic       dir,
  input logic       rx_full,
  input logic       crc_rdy,
  input logic       tx_empty,
  input logic       nack,
  input logic       reg_wr,
  input logic [1:0] reg_sel
);
  localparam logic [2:0] C_IDLE = 3'd0;
  localparam logic [2:0] C_ADDR = 3'd1;
  localparam logic [2:0] C_RX   = 3'd2;
  localparam logic [2:0] C_TX   = 3'd3;

  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state == C_IDLE |-> !sda_oe);

  assert_sda_steady_scl_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q) |-> $stable(sda_oe));

  assert_dir_only_after_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir) |-> $past(state) == C_ADDR);

  assert_rx_full_from_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(state) == C_RX);

  assert_tx_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0) |=> !tx_empty);

  assert_nack_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack) |-> !sda_oe);

  assert_crc_rdy_at_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_rdy) |-> ($past(state) == C_RX || $past(state) == C_TX));
endmodule

bind i2c_pec_slave i2c_pec_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_q(scl_q), .sda_oe(sda_oe),
  .state(state), .dir(dir), .rx_full(rx_full), .crc_rdy(crc_rdy),
  .tx_empty(tx_empty), .nack(nack), .reg_wr(reg_wr), .reg_sel(reg_sel)
);

// File: tb/test_i2c_pec_slave.sv
module test_i2c_pec_slave;
  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h2B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic [1:0] reg_sel = 2'd0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  wire sda_line = m_sda & ~sda_oe;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  i2c_pec_slave i_i2c_pec_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .own_addr(OWN), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic qw; repeat (Q) @(negedge clk); endtask

  task automatic cpu_wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic m_start;
    m_sda = 1'b1; qw; m_scl = 1'b1; qw; m_sda = 1'b0; qw; m_scl = 1'b0; qw;
  endtask

  task automatic m_stop;
    m_sda = 1'b0; qw; m_scl = 1'b1; qw; m_sda = 1'b1; qw;
  endtask

  task automatic m_bit_out(input logic b);
    m_sda = b; qw; m_scl = 1'b1; qw; qw; m_scl = 1'b0; qw;
  endtask

  task automatic m_bit_in(output logic b);
    m_sda = 1'b1; qw; m_scl = 1'b1; qw; b = sda_line; qw; m_scl = 1'b0; qw;
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic ack_low);
    logic b;
    for (int i = 7; i >= 0; i--) m_bit_out(d[i]);
    m_bit_in(b);
    ack_low = ~b;
  endtask

  task automatic m_rbyte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) m_bit_in(d[i]);
    m_bit_out(~give_ack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v, crc_e, c1;
    logic ack;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    cpu_rd(2'd3, v); chk("R1 status", v, 8'h0A);
    cpu_rd(2'd0, v); chk("R1 txdata", v, 8'h00);
    chk("R1 sda_oe", {7'b0, sda_oe}, 8'h00);

    // R2/R3 full address sweep, write direction
    for (int a = 0; a < 128; a++) begin
      m_start;
      m_wbyte({a[6:0], 1'b0}, ack);
      if (a[6:0] == OWN) chk("R3 own address acked", {7'b0, ack}, 8'h01);
      else if (ack) chk("R2 foreign address acked", {1'b0, a[6:0]}, 8'hFF);
      m_stop;
    end
    total++;
    cpu_rd(2'd3, v); chk("R2 status after sweep", v, 8'h0A);

    // R5/R9 receive stream with running CRC
    m_start;
    m_wbyte({OWN, 1'b0}, ack); chk("R3 ack write addr", {7'b0, ack}, 8'h01);
    crc_e = crc8(8'h00, {OWN, 1'b0});
    cpu_rd(2'd3, v); chk("R4 dir write", {7'b0, v[4]}, 8'h00);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] d = 8'(k * 8'h1D + 8'h5A);
      m_wbyte(d, ack);
      chk("R5 data ack", {7'b0, ack}, 8'h01);
      crc_e = crc8(crc_e, d);
      cpu_rd(2'd3, v); chk("R5/R9 rx_full crc_rdy", {6'b0, v[2], v[0]}, 8'h03);
      cpu_rd(2'd1, v); chk("R5 rx data", v, d);
      cpu_rd(2'd2, v); chk("R9 crc", v, crc_e);
      cpu_rd(2'd3, v); chk("R5/R9 flags cleared", {6'b0, v[2], v[0]}, 8'h00);
    end
    m_stop;

    // R6/R7/R8/R9 transmit
    cpu_wr(2'd0, 8'hA5);
    cpu_rd(2'd3, v); chk("R6 tx_empty cleared", {7'b0, v[1]}, 8'h00);
    m_start;
    m_wbyte({OWN, 1'b1}, ack); chk("R3 ack read addr", {7'b0, ack}, 8'h01);
    cpu_rd(2'd3, v); chk("R4 dir read", {7'b0, v[4]}, 8'h01);
    chk("R6 tx_empty after load", {7'b0, v[1]}, 8'h01);
    crc_e = crc8(8'h00, {OWN, 1'b1});
    m_rbyte(1'b1, v); chk("R6 tx byte", v, 8'hA5);
    crc_e = crc8(crc_e, 8'hA5);
    cpu_rd(2'd3, v); chk("R8 nack clear on ack", {7'b0, v[3]}, 8'h00);
    chk("R9 crc_rdy tx", {7'b0, v[2]}, 8'h01);
    cpu_rd(2'd2, c1); chk("R9 crc tx", c1, crc_e);
    cpu_wr(2'd0, c1);
    m_rbyte(1'b1, v); chk("R7 empty sends FF", v, 8'hFF);
    crc_e = crc8(crc_e, 8'hFF);
    m_rbyte(1'b0, v); chk("R9 crc byte sent", v, c1);
    crc_e = crc8(crc_e, c1);
    cpu_rd(2'd3, v); chk("R8 nack set", {7'b0, v[3]}, 8'h01);
    chk("R8 deselected", {7'b0, v[5]}, 8'h00);
    chk("R8 sda released", {7'b0, sda_oe}, 8'h00);
    cpu_rd(2'd2, v); chk("R9 crc chain", v, crc_e);
    m_stop;

    // R10 repeated START
    m_start;
    m_wbyte({OWN, 1'b0}, ack);
    m_wbyte(8'h3C, ack); chk("R10 data ack", {7'b0, ack}, 8'h01);
    cpu_rd(2'd1, v);
    m_start;
    m_wbyte({OWN, 1'b1}, ack); chk("R10 readdress ack", {7'b0, ack}, 8'h01);
    cpu_rd(2'd3, v); chk("R10 dir read", {7'b0, v[4]}, 8'h01);
    m_rbyte(1'b0, v); chk("R10/R7 byte", v, 8'hFF);
    cpu_rd(2'd2, v); chk("R10 crc restart", v, crc8(crc8(8'h00, {OWN, 1'b1}), 8'hFF));
    m_stop;
    cpu_rd(2'd3, v); chk("R2 idle after stop", {7'b0, v[5]}, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule